// File: doc/BRIEF.md
# Low-Power Standby Mode Controller

This block sequences the clock and power modes of a small microcontroller. When the CPU issues its sleep strobe, the controller reads the standby-select, low-speed-select and watchdog clock-select control bits. From these it either gates only the CPU clock (ordinary sleep), or stops the oscillator and every clock (software standby), or ignores the strobe. It also watches a set of wake inputs: a non-maskable interrupt, six external interrupt lines, eight wake pins, an active-low reset pin and an active-low hardware-standby pin. It brings the clocks back in a way that depends on which source fired.

An interrupt wake from software standby first restarts the oscillator. A down-counter then runs for the settling interval picked by a 3-bit select. Only after that are the CPU and peripheral clocks released and a one-cycle interrupt-exception start issued. A reset-pin wake turns every clock on at once and issues a one-cycle reset-exception start when the pin is released. A low standby pin forces hardware standby from any mode, ahead of every other source.

The counter runs on an always-on reference clock, `clk`. The clock-enable outputs are registered, so they change on the same edge as the mode register. States: ACTIVE, SLEEP, SWSTBY (software standby), SETTLE (oscillator settling), RSTWAKE (reset held after a wake) and HWSTBY (hardware standby). Transitions:
- ACTIVE→SLEEP on a strobe with standby-select 0.
- ACTIVE→SWSTBY on a strobe with standby-select 1, low-speed 0 and watchdog select 0.
- SLEEP→ACTIVE on a qualified wake.
- SWSTBY→SETTLE on a qualified wake.
- SETTLE→ACTIVE when the count expires.
- Any of ACTIVE, SLEEP, SWSTBY or SETTLE→RSTWAKE when the reset pin is low.
- RSTWAKE→ACTIVE when the reset pin is high.
- Any state→HWSTBY when the standby pin is low.
- HWSTBY→RSTWAKE when the standby pin is high and the reset pin is low.

Top module: `pwr_standby_seq`

## Requirements
- R1: After `rst_n` is released the block is ACTIVE. The outputs {osc_en, cpu_clk_en, per_clk_en, adc_rst, irq_exc_start, rst_exc_start} read 111000.
- R2: A sleep strobe with stby_sel=1, lowspd_sel=0 and wdt_clksel=0 enters software standby on the next edge. The outputs read 000100: oscillator and all clocks off, A/D converter held in reset.
- R3: A sleep strobe with stby_sel=1 and either lowspd_sel=1 or wdt_clksel=1 has no effect. The outputs stay at 111000.
- R4: A sleep strobe with stby_sel=0 enters ordinary sleep, with outputs 101000 (only the CPU clock gated). A qualified wake returns to active on the next edge, with irq_exc_start high for that one cycle.
- R5: A qualified wake is any of the following:
  - `nmi`, which is always enabled.
  - Interrupt line i, for i in {0,1,3,4,5}, when irq[i]=1, irq_en[i]=1, irq_xfer[i]=0 and cpu_mask=0. Line 2 never wakes the block.
  - Wake pin j, for j in 0..7, when wkp[j]=1, wkp_en[j]=1, wkp_xfer[j]=0 and cpu_mask=0.
- R6: A qualified wake in software standby turns osc_en on at the next edge while the CPU and peripheral clocks stay off (outputs 100100). The settling wait runs for N clock cycles, where N depends on settle_sel sampled at the wake:
  - codes 0 to 5 give 8192·2^code;
  - code 6 gives 2048;
  - code 7 gives 16.
- R7: On the first edge after the N settling cycles, all clocks turn on, adc_rst drops, and irq_exc_start is high for exactly one cycle.
- R8: With stbyn_pin high, a low level on resn_pin in any mode other than hardware standby turns the oscillator, CPU clock and peripheral clocks on at the next edge, with no settling wait and no interrupt-exception start.
- R9: When resn_pin returns high after a reset wake, the block goes ACTIVE and pulses rst_exc_start for one cycle.
- R10: A low stbyn_pin forces hardware standby (outputs 000100) at the next edge from any mode. This holds even while nmi, interrupt lines or resn_pin are asserted.
- R11: Hardware standby is left only when stbyn_pin is high and resn_pin is low. That enters the reset-wake state (outputs 111000). With both pins high, the block stays in hardware standby.
- R12: Wake requests while ACTIVE change no output and give no irq_exc_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| stby_sel | input | 1 | 1 selects software standby on sleep |
| lowspd_sel | input | 1 | Low-speed select; 1 blocks software standby |
| wdt_clksel | input | 1 | Watchdog clock select; 1 blocks software standby |
| settle_sel | input | 3 | Oscillator settling-time code |
| nmi | input | 1 | Non-maskable interrupt request |
| irq | input | 6 | External interrupt requests |
| irq_en | input | 6 | Per-line interrupt enables |
| irq_xfer | input | 6 | Line assigned to the transfer controller |
| wkp | input | 8 | Wake pin requests |
| wkp_en | input | 8 | Per-pin wake function enables |
| wkp_xfer | input | 8 | Pin assigned to the transfer controller |
| cpu_mask | input | 1 | CPU-side mask of maskable interrupts |
| resn_pin | input | 1 | Reset pin, active low |
| stbyn_pin | input | 1 | Hardware-standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| adc_rst | output | 1 | A/D converter reset |
| irq_exc_start | output | 1 | One-cycle interrupt-exception start |
| rst_exc_start | output | 1 | One-cycle reset-exception start |

## Verification
The bench walks the wake qualifier through a table of request patterns. These include the missing line 2, transfer-controller and CPU-side masking, and an enable set on the wrong pin; a qualifier that ignored any of them would wake from sleep when it must not, or fail to wake. Settling is timed for codes 7, 6 and 0 by checking the cycle just before release and the release cycle itself. An off-by-one counter or a wrong code mapping shows up as clocks turning on one cycle early or late. A reset wake during settling must bring the clocks on at once, without an interrupt start. A standby pin pulled low while nmi and reset are active must still win. Hardware standby must ignore a release that comes with the reset pin high.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE,
        PM_SLEEP,
        PM_SWSTBY,
        PM_SETTLE,
        PM_RSTWAKE,
        PM_HWSTBY
    } pmode_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
        logic adc_rst;
    } clk_ctl_t;

    // Clock and reset levels held in each mode
    function automatic clk_ctl_t mode_levels(input pmode_e m);
        clk_ctl_t c;
        unique case (m)
            PM_ACTIVE:  c = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, adc_rst: 1'b0};
            PM_SLEEP:   c = '{osc: 1'b1, cpu: 1'b0, per: 1'b1, adc_rst: 1'b0};
            PM_SWSTBY:  c = '{osc: 1'b0, cpu: 1'b0, per: 1'b0, adc_rst: 1'b1};
            PM_SETTLE:  c = '{osc: 1'b1, cpu: 1'b0, per: 1'b0, adc_rst: 1'b1};
            PM_RSTWAKE: c = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, adc_rst: 1'b0};
            PM_HWSTBY:  c = '{osc: 1'b0, cpu: 1'b0, per: 1'b0, adc_rst: 1'b1};
            default:    c = '{osc: 1'b1, cpu: 1'b1, per: 1'b1, adc_rst: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wake_qual.sv
module wake_qual #(
    parameter int          IRQ_N         = 6,
    parameter int          WKP_N         = 8,
    parameter logic [IRQ_N-1:0] IRQ_WAKE_MASK = 6'b111011
) (
    input  logic             nmi,
    input  logic [IRQ_N-1:0] irq,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic [IRQ_N-1:0] irq_xfer,
    input  logic [WKP_N-1:0] wkp,
    input  logic [WKP_N-1:0] wkp_en,
    input  logic [WKP_N-1:0] wkp_xfer,
    input  logic             cpu_mask,
    output logic             wake
);

    logic [IRQ_N-1:0] irq_ok;
    logic [WKP_N-1:0] wkp_ok;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        // Lines absent from the wake mask never qualify
        assign irq_ok[i] = IRQ_WAKE_MASK[i] & irq[i] & irq_en[i] & ~irq_xfer[i];
    end

    for (genvar j = 0; j < WKP_N; j++) begin : g_wkp
        assign wkp_ok[j] = wkp[j] & wkp_en[j] & ~wkp_xfer[j];
    end

    assign wake = nmi | (~cpu_mask & ((|irq_ok) | (|wkp_ok)));

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 13,
    parameter int ALT_LOG2  = 11,
    parameter int MIN_LOG2  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    // Codes 0..DOUBLE_CODES-1 double the base interval each step
    localparam int DOUBLE_CODES = 6;
    localparam int CNT_W        = BASE_LOG2 + DOUBLE_CODES - 1;
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wait_m1;

    always_comb begin
        if (int'(sel) == DOUBLE_CODES)
            wait_m1 = ONES >> (CNT_W - ALT_LOG2);
        else if (int'(sel) > DOUBLE_CODES)
            wait_m1 = ONES >> (CNT_W - MIN_LOG2);
        else
            wait_m1 = ONES >> (DOUBLE_CODES - 1 - int'(sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= wait_m1;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pwr_standby_seq.sv
module pwr_standby_seq
    import pwr_seq_pkg::*;
#(
    parameter int          IRQ_N         = 6,
    parameter int          WKP_N         = 8,
    parameter logic [IRQ_N-1:0] IRQ_WAKE_MASK = 6'b111011,
    parameter int          SEL_W         = 3,
    parameter int          BASE_LOG2     = 13,
    parameter int          ALT_LOG2      = 11,
    parameter int          MIN_LOG2      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_stb,
    input  logic             stby_sel,
    input  logic             lowspd_sel,
    input  logic             wdt_clksel,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             nmi,
    input  logic [IRQ_N-1:0] irq,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic [IRQ_N-1:0] irq_xfer,
    input  logic [WKP_N-1:0] wkp,
    input  logic [WKP_N-1:0] wkp_en,
    input  logic [WKP_N-1:0] wkp_xfer,
    input  logic             cpu_mask,
    input  logic             resn_pin,
    input  logic             stbyn_pin,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             adc_rst,
    output logic             irq_exc_start,
    output logic             rst_exc_start
);

    pmode_e   state, nxt;
    clk_ctl_t lv;
    logic     wake;
    logic     settle_done;
    logic     settle_load;
    logic     settle_run;

    wake_qual #(
        .IRQ_N        (IRQ_N),
        .WKP_N        (WKP_N),
        .IRQ_WAKE_MASK(IRQ_WAKE_MASK)
    ) u_wake (
        .nmi     (nmi),
        .irq     (irq),
        .irq_en  (irq_en),
        .irq_xfer(irq_xfer),
        .wkp     (wkp),
        .wkp_en  (wkp_en),
        .wkp_xfer(wkp_xfer),
        .cpu_mask(cpu_mask),
        .wake    (wake)
    );

    assign settle_load = (state == PM_SWSTBY) && (nxt == PM_SETTLE);
    assign settle_run  = (state == PM_SETTLE);

    settle_timer #(
        .SEL_W    (SEL_W),
        .BASE_LOG2(BASE_LOG2),
        .ALT_LOG2 (ALT_LOG2),
        .MIN_LOG2 (MIN_LOG2)
    ) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .load (settle_load),
        .run  (settle_run),
        .sel  (settle_sel),
        .done (settle_done)
    );

    // Next-mode selection; the standby pin outranks every other source
    always_comb begin
        nxt = state;
        if (!stbyn_pin) begin
            nxt = PM_HWSTBY;
        end else begin
            unique case (state)
                PM_ACTIVE: begin
                    if (!resn_pin)
                        nxt = PM_RSTWAKE;
                    else if (sleep_stb && !stby_sel)
                        nxt = PM_SLEEP;
                    else if (sleep_stb && !lowspd_sel && !wdt_clksel)
                        nxt = PM_SWSTBY;
                end
                PM_SLEEP: begin
                    if (!resn_pin)  nxt = PM_RSTWAKE;
                    else if (wake)  nxt = PM_ACTIVE;
                end
                PM_SWSTBY: begin
                    if (!resn_pin)  nxt = PM_RSTWAKE;
                    else if (wake)  nxt = PM_SETTLE;
                end
                PM_SETTLE: begin
                    if (!resn_pin)        nxt = PM_RSTWAKE;
                    else if (settle_done) nxt = PM_ACTIVE;
                end
                PM_RSTWAKE: begin
                    if (resn_pin)   nxt = PM_ACTIVE;
                end
                PM_HWSTBY: begin
                    if (!resn_pin)  nxt = PM_RSTWAKE;
                end
                default: nxt = PM_ACTIVE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_ACTIVE;
        else        state <= nxt;
    end

    assign lv = mode_levels(nxt);

    // Output register: levels follow the mode, exception starts mark exits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_en        <= 1'b1;
            cpu_clk_en    <= 1'b1;
            per_clk_en    <= 1'b1;
            adc_rst       <= 1'b0;
            irq_exc_start <= 1'b0;
            rst_exc_start <= 1'b0;
        end else begin
            osc_en        <= lv.osc;
            cpu_clk_en    <= lv.cpu;
            per_clk_en    <= lv.per;
            adc_rst       <= lv.adc_rst;
            irq_exc_start <= (nxt == PM_ACTIVE) &&
                             ((state == PM_SETTLE) || (state == PM_SLEEP));
            rst_exc_start <= (nxt == PM_ACTIVE) && (state == PM_RSTWAKE);
        end
    end

endmodule

// File: rtl/pwr_standby_chk.sv
module pwr_standby_chk (
    input logic clk,
    input logic rst_n,
    input logic resn_pin,
    input logic stbyn_pin,
    input logic osc_en,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic adc_rst,
    input logic irq_exc_start,
    input logic rst_exc_start
);

    a_r10_standby_pin_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !stbyn_pin |=> (!osc_en && !cpu_clk_en && !per_clk_en && adc_rst));

    a_r8_reset_clocks_now: assert property (@(posedge clk) disable iff (!rst_n)
        (!resn_pin && stbyn_pin) |=> (osc_en && cpu_clk_en && per_clk_en && !irq_exc_start));

    a_r7_irq_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_exc_start |=> !irq_exc_start);

    a_r7_irq_start_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
        irq_exc_start |-> (osc_en && cpu_clk_en && per_clk_en && !adc_rst));

    a_r9_rst_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_exc_start |=> !rst_exc_start);

    a_r2_adc_reset_gates: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rst |-> (!cpu_clk_en && !per_clk_en));

endmodule

bind pwr_standby_seq pwr_standby_chk u_chk (.*);

// File: tb/test_pwr_standby_seq.sv
`timescale 1ns/1ps
module test_pwr_standby_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_stb, stby_sel, lowspd_sel, wdt_clksel;
    logic [2:0] settle_sel;
    logic       nmi, cpu_mask, resn_pin, stbyn_pin;
    logic [5:0] irq, irq_en, irq_xfer;
    logic [7:0] wkp, wkp_en, wkp_xfer;
    logic       osc_en, cpu_clk_en, per_clk_en, adc_rst, irq_exc_start, rst_exc_start;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    localparam logic [5:0] O_ACT  = 6'b111000;
    localparam logic [5:0] O_SLP  = 6'b101000;
    localparam logic [5:0] O_SWS  = 6'b000100;
    localparam logic [5:0] O_SET  = 6'b100100;
    localparam logic [5:0] O_HWS  = 6'b000100;
    localparam logic [5:0] O_IRQX = 6'b111010;
    localparam logic [5:0] O_RSTX = 6'b111001;

    typedef struct packed {
        logic       v_nmi;
        logic       v_mask;
        logic [5:0] v_irq, v_ien, v_ixf;
        logic [7:0] v_wkp, v_wen, v_wxf;
        logic       v_exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 6'h00, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 1'b1},
        '{1'b1, 1'b1, 6'h00, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 1'b1},
        '{1'b0, 1'b0, 6'h01, 6'h01, 6'h00, 8'h00, 8'h00, 8'h00, 1'b1},
        '{1'b0, 1'b0, 6'h01, 6'h00, 6'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        '{1'b0, 1'b0, 6'h04, 6'h04, 6'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        '{1'b0, 1'b0, 6'h20, 6'h20, 6'h20, 8'h00, 8'h00, 8'h00, 1'b0},
        '{1'b0, 1'b1, 6'h10, 6'h10, 6'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        '{1'b0, 1'b0, 6'h00, 6'h00, 6'h00, 8'h80, 8'h80, 8'h00, 1'b1},
        '{1'b0, 1'b0, 6'h00, 6'h00, 6'h00, 8'h08, 8'h08, 8'h08, 1'b0},
        '{1'b0, 1'b0, 6'h08, 6'h08, 6'h00, 8'h01, 8'h00, 8'h00, 1'b1},
        '{1'b0, 1'b0, 6'h00, 6'h00, 6'h00, 8'h04, 8'h20, 8'h00, 1'b0},
        '{1'b0, 1'b1, 6'h02, 6'h02, 6'h00, 8'h40, 8'h40, 8'h00, 1'b0}
    };

    always #2.5 clk = ~clk;

    pwr_standby_seq i_pwr_standby_seq (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .stby_sel(stby_sel),
        .lowspd_sel(lowspd_sel), .wdt_clksel(wdt_clksel), .settle_sel(settle_sel),
        .nmi(nmi), .irq(irq), .irq_en(irq_en), .irq_xfer(irq_xfer),
        .wkp(wkp), .wkp_en(wkp_en), .wkp_xfer(wkp_xfer), .cpu_mask(cpu_mask),
        .resn_pin(resn_pin), .stbyn_pin(stbyn_pin), .osc_en(osc_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .adc_rst(adc_rst),
        .irq_exc_start(irq_exc_start), .rst_exc_start(rst_exc_start)
    );

    wire [5:0] outs = {osc_en, cpu_clk_en, per_clk_en, adc_rst, irq_exc_start, rst_exc_start};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [5:0] exp);
        total++;
        if (outs !== exp) begin
            bad++;
            $display("FAIL %s: outs=%b expected %b", req, outs, exp);
        end
    endtask

    task automatic clear_wake();
        nmi = 0; cpu_mask = 0;
        irq = '0; irq_en = '0; irq_xfer = '0;
        wkp = '0; wkp_en = '0; wkp_xfer = '0;
    endtask

    task automatic sleep_req(input logic sb);
        stby_sel = sb; sleep_stb = 1'b1;
        step(1);
        sleep_stb = 1'b0;
    endtask

    // Standby, wake through the given sources, time the settling window
    task automatic settle_run(input logic [2:0] code, input int n, input string req,
                              input logic [5:0] ri, input logic [7:0] rw);
        settle_sel = code;
        sleep_req(1'b1);
        chk({req, " R2 standby entry"}, O_SWS);
        irq = ri; irq_en = ri; wkp = rw; wkp_en = rw; nmi = (ri == 0 && rw == 0);
        step(1);
        clear_wake();
        chk({req, " R6 oscillator on, clocks held"}, O_SET);
        step(n - 1);
        chk({req, " R6 last settling cycle"}, O_SET);
        step(1);
        chk({req, " R7 release with irq start"}, O_IRQX);
        step(1);
        chk({req, " R7 irq start one cycle"}, O_ACT);
    endtask

    initial begin
        rst_n = 1'b0; sleep_stb = 0; stby_sel = 0; lowspd_sel = 0; wdt_clksel = 0;
        settle_sel = 3'd7; resn_pin = 1; stbyn_pin = 1;
        clear_wake();
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset state", O_ACT);

        // Table walk: wake qualification from ordinary sleep
        for (int i = 0; i < NV; i++) begin
            clear_wake();
            sleep_req(1'b0);
            chk("R4 sleep entry", O_SLP);
            nmi = VECS[i].v_nmi; cpu_mask = VECS[i].v_mask;
            irq = VECS[i].v_irq; irq_en = VECS[i].v_ien; irq_xfer = VECS[i].v_ixf;
            wkp = VECS[i].v_wkp; wkp_en = VECS[i].v_wen; wkp_xfer = VECS[i].v_wxf;
            step(1);
            chk($sformatf("R5 wake vector %0d", i), VECS[i].v_exp ? O_IRQX : O_SLP);
            clear_wake();
            if (!VECS[i].v_exp) begin
                nmi = 1'b1;
                step(1);
                nmi = 1'b0;
                chk("R4 nmi returns from sleep", O_IRQX);
            end
            step(1);
        end

        // R3: standby blocked by low-speed or watchdog select
        lowspd_sel = 1'b1;
        sleep_req(1'b1);
        chk("R3 low-speed blocks standby", O_ACT);
        lowspd_sel = 1'b0; wdt_clksel = 1'b1;
        sleep_req(1'b1);
        chk("R3 watchdog select blocks standby", O_ACT);
        wdt_clksel = 1'b0;

        // R12: requests while active do nothing
        nmi = 1'b1; irq = 6'h01; irq_en = 6'h01;
        step(2);
        chk("R12 wake while active", O_ACT);
        clear_wake();

        // R6/R7: settling codes
        settle_run(3'd7, 16,   "code7", 6'h00, 8'h00);
        settle_run(3'd6, 2048, "code6", 6'h02, 8'h00);
        settle_run(3'd0, 8192, "code0", 6'h00, 8'h20);

        // R8/R9: reset during settling
        settle_sel = 3'd0;
        sleep_req(1'b1);
        nmi = 1'b1; step(1); nmi = 1'b0;
        chk("R6 settling before reset", O_SET);
        step(100);
        resn_pin = 1'b0;
        step(1);
        chk("R8 reset during settling clocks on", O_ACT);
        step(3);
        chk("R8 reset held", O_ACT);
        resn_pin = 1'b1;
        step(1);
        chk("R9 reset exception start", O_RSTX);
        step(1);
        chk("R9 reset start one cycle", O_ACT);

        // R8: reset straight from software standby
        sleep_req(1'b1);
        resn_pin = 1'b0;
        step(1);
        chk("R8 reset from standby", O_ACT);
        resn_pin = 1'b1;
        step(1);
        chk("R9 reset start after standby", O_RSTX);
        step(1);

        // R10/R11: hardware standby from active with competing sources
        stbyn_pin = 1'b0; nmi = 1'b1; resn_pin = 1'b0;
        step(1);
        chk("R10 standby pin over nmi and reset", O_HWS);
        step(4);
        chk("R10 hardware standby held", O_HWS);
        nmi = 1'b0; resn_pin = 1'b1; stbyn_pin = 1'b1;
        step(3);
        chk("R11 stays with reset high", O_HWS);
        resn_pin = 1'b0;
        step(1);
        chk("R11 exit into reset wake", O_ACT);
        resn_pin = 1'b1;
        step(1);
        chk("R11 reset start after hardware standby", O_RSTX);
        step(1);

        // R10: from settling
        settle_sel = 3'd0;
        sleep_req(1'b1);
        nmi = 1'b1; step(1);
        stbyn_pin = 1'b0;
        step(1);
        chk("R10 standby pin during settling", O_HWS);
        nmi = 1'b0; stbyn_pin = 1'b1; resn_pin = 1'b0;
        step(1); resn_pin = 1'b1; step(2);

        // R1: reset while in standby returns to active
        sleep_req(1'b1);
        chk("R2 standby before power-on reset", O_SWS);
        rst_n = 1'b0;
        step(1);
        chk("R1 reset from standby", O_ACT);
        rst_n = 1'b1;
        step(1);
        chk("R1 active after reset release", O_ACT);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule